// File: doc/BRIEF.md
# Down-Counting Decrementer with 64-bit Time Base

This block is the system timer of a processor core. It has two counters. One is a 32-bit decrementer that counts down and raises an exception request. The other is a 64-bit time base that counts up. Both counters advance on a shared periodic tick enable. Software reaches them through a small register port: a two-bit address, a write strobe, write data and a combinational read-data bus. The read bus always shows the live count.

The exception request is edge based. It goes high for one cycle after the top bit of the decrementer goes from 0 to 1, which happens when the count steps from zero into the negative range. A write can also cause that change. Two resets are modelled. The power-on reset clears everything. The synchronous system reset (hard or soft) keeps both counters running and leaves their values untouched. While it is held, it blocks register writes and silences the exception request.

Top module: `sys_timer`

## Requirements
- R1: While `porRst_n` is low, and at its release, the decrementer and both time-base halves read as zero and `decIrq` is low.
- R2: In each cycle with `tick` high and no accepted decrementer write, the decrementer drops by one, wrapping from 0x00000000 to 0xFFFFFFFF. With no tick and no write it holds.
- R3: In each cycle with `tick` high and no accepted time-base write, the 64-bit time base rises by one. A carry out of the low half reaches the high half in the same cycle.
- R4: Address map: 0 is the decrementer, 1 is the time-base low half and 2 is the time-base high half. Address 3 reads as zero and ignores writes. `regRdata` shows the addressed register's current value in the same cycle.
- R5: A write with `regWe` high stores `regWdata` into the addressed register at the next clock edge. Counting then continues from the stored value.
- R6: A write in a tick cycle wins over counting. For the decrementer, the written value is stored without a decrement. For a time-base write, the written half takes the data and the other half holds for that cycle.
- R7: When counting moves decrementer bit 31 from 0 to 1, `decIrq` is high for exactly the one cycle after that edge.
- R8: A write that changes bit 31 from 0 to 1 raises `decIrq` for the one cycle after the write. A write that leaves bit 31 at 1, or clears it, raises nothing.
- R9: While `sysRst` is high, both counters keep their values and keep counting on ticks, writes are ignored, and `decIrq` stays low. No stale pulse follows the release of `sysRst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst_n | input | 1 | Power-on reset, asynchronous, active low |
| sysRst | input | 1 | Hard/soft system reset, synchronous, active high |
| tick | input | 1 | Periodic count enable |
| regAddr | input | 2 | Register select |
| regWe | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Live read data of the addressed register |
| decIrq | output | 1 | One-cycle decrementer exception request |

## Verification
The bench targets the zero-to-negative wrap. A design that fires on reaching zero would pulse one tick early, and a level-based design would hold the request high for as long as the count stays negative. It loads 0xFFFFFFFF into the low time-base half and ticks. A broken carry shows up as a high half that does not advance, or that advances one cycle late. It places writes in tick cycles, where a wrong priority leaves the stored value off by one. It runs a negative crossing under system reset, where a design that clears the counters or keeps the edge detector stale would lose the count or send a late pulse once the reset is released.

// File: rtl/sys_timer_pkg.sv
`timescale 1ns/1ps
package sys_timer_pkg;

  typedef enum logic [1:0] {
    SEL_DEC  = 2'd0,
    SEL_TBLO = 2'd1,
    SEL_TBHI = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic decLoad;
    logic decStep;
    logic tbLoLoad;
    logic tbHiLoad;
    logic tbStep;
  } timerStrobe_t;

endpackage

// File: rtl/sys_timer_ctrl.sv
`timescale 1ns/1ps
module sys_timer_ctrl
  import sys_timer_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              tick,
  input  logic              sysRst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output timerStrobe_t      strb
);

  logic    wrOk;
  regSel_e sel;
  logic    anyTbLoad;

  assign wrOk = regWe & ~sysRst;
  assign sel  = regSel_e'(regAddr[1:0]);

  always_comb begin
    strb          = '0;
    strb.decLoad  = wrOk && (sel == SEL_DEC);
    strb.tbLoLoad = wrOk && (sel == SEL_TBLO);
    strb.tbHiLoad = wrOk && (sel == SEL_TBHI);
    strb.decStep  = tick && !strb.decLoad;
    strb.tbStep   = tick && !anyTbLoad;
  end

  assign anyTbLoad = wrOk && ((sel == SEL_TBLO) || (sel == SEL_TBHI));

endmodule

// File: rtl/sys_timer_dp.sv
`timescale 1ns/1ps
module sys_timer_dp
  import sys_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                porRst_n,
  input  logic                sysRst,
  input  timerStrobe_t        strb,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic [DATA_W-1:0]   decVal,
  output logic [2*DATA_W-1:0] tbVal,
  output logic                decIrq
);

  localparam int HALVES = 2;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] decCnt;
  logic              msbPrev;
  logic [DATA_W-1:0] tbHalf [HALVES];
  logic [HALVES-1:0] halfLoad;
  logic [HALVES:0]   carry;

  // decrementer
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      decCnt  <= '0;
      msbPrev <= 1'b0;
    end else begin
      msbPrev <= decCnt[MSB];
      if (strb.decLoad)      decCnt <= regWdata;
      else if (strb.decStep) decCnt <= decCnt - 1'b1;
    end
  end

  // time base: halves chained by carry
  assign halfLoad = {strb.tbHiLoad, strb.tbLoLoad};
  assign carry[0] = strb.tbStep;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign carry[h+1] = carry[h] & (&tbHalf[h]);
    always_ff @(posedge clk or negedge porRst_n) begin
      if (!porRst_n)        tbHalf[h] <= '0;
      else if (halfLoad[h]) tbHalf[h] <= regWdata;
      else if (carry[h])    tbHalf[h] <= tbHalf[h] + 1'b1;
    end
  end

  assign tbVal  = {tbHalf[1], tbHalf[0]};
  assign decVal = decCnt;
  assign decIrq = decCnt[MSB] & ~msbPrev & ~sysRst;

  always_comb begin
    unique case (regSel_e'(regAddr[1:0]))
      SEL_DEC:  regRdata = decCnt;
      SEL_TBLO: regRdata = tbHalf[0];
      SEL_TBHI: regRdata = tbHalf[1];
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/sys_timer.sv
`timescale 1ns/1ps
module sys_timer
  import sys_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              sysRst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              decIrq
);

  localparam int TB_W = 2 * DATA_W;

  timerStrobe_t      strb;
  logic [DATA_W-1:0] decVal;
  logic [TB_W-1:0]   tbVal;

  sys_timer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .tick    (tick),
    .sysRst  (sysRst),
    .regWe   (regWe),
    .regAddr (regAddr),
    .strb    (strb)
  );

  sys_timer_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .porRst_n (porRst_n),
    .sysRst   (sysRst),
    .strb     (strb),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .decVal   (decVal),
    .tbVal    (tbVal),
    .decIrq   (decIrq)
  );

endmodule

// File: rtl/sys_timer_chk.sv
`timescale 1ns/1ps
module sys_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic                clk,
  input logic                porRst_n,
  input logic                sysRst,
  input logic                tick,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWe,
  input logic [DATA_W-1:0]   regWdata,
  input logic                decIrq,
  input logic [DATA_W-1:0]   decVal,
  input logic [2*DATA_W-1:0] tbVal
);

  logic decWr, tbWr;
  assign decWr = regWe && !sysRst && (regAddr == 2'd0);
  assign tbWr  = regWe && !sysRst && ((regAddr == 2'd1) || (regAddr == 2'd2));

  assert_dec_count_R2: assert property (@(posedge clk) disable iff (!porRst_n)
    (tick && !decWr) |=> (decVal == $past(decVal) - 1'b1));

  assert_dec_hold_R2: assert property (@(posedge clk) disable iff (!porRst_n)
    (!tick && !decWr) |=> $stable(decVal));

  assert_tb_count_R3: assert property (@(posedge clk) disable iff (!porRst_n)
    (tick && !tbWr) |=> (tbVal == $past(tbVal) + 1'b1));

  assert_dec_load_R5: assert property (@(posedge clk) disable iff (!porRst_n)
    decWr |=> (decVal == $past(regWdata)));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!porRst_n)
    decIrq |=> !decIrq);

  assert_irq_edge_R8: assert property (@(posedge clk) disable iff (!porRst_n)
    decIrq |-> (decVal[DATA_W-1] && !$past(decVal[DATA_W-1])));

  assert_sysrst_quiet_R9: assert property (@(posedge clk) disable iff (!porRst_n)
    sysRst |-> !decIrq);

endmodule

bind sys_timer sys_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .porRst_n (porRst_n),
  .sysRst   (sysRst),
  .tick     (tick),
  .regAddr  (regAddr),
  .regWe    (regWe),
  .regWdata (regWdata),
  .decIrq   (decIrq),
  .decVal   (decVal),
  .tbVal    (tbVal)
);

// File: tb/test_sys_timer.sv
`timescale 1ns/1ps
module test_sys_timer;

  logic        clk = 1'b0;
  logic        porRst_n = 1'b0;
  logic        sysRst = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        decIrq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // reference model state
  logic [31:0] mDec = '0;
  logic [31:0] mTbl = '0;
  logic [31:0] mTbu = '0;

  typedef struct {
    logic [1:0]  addr;
    logic [31:0] exp;
    string       req;
  } rdItem_t;
  rdItem_t rdQ [$];

  always #2.5 clk = ~clk;

  sys_timer i_sys_timer (
    .clk(clk), .porRst_n(porRst_n), .sysRst(sysRst), .tick(tick),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .decIrq(decIrq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mDec;
      2'd1: return mTbl;
      2'd2: return mTbu;
      default: return 32'h0;
    endcase
  endfunction

  // driver: one cycle of stimulus, model update, exception check
  task automatic step(input bit t, input bit w, input logic [1:0] a, input logic [31:0] d, input string req);
    logic oldMsb;
    logic wrOk;
    logic expIrq;
    @(negedge clk);
    tick = t; regWe = w; regAddr = a; regWdata = d;
    oldMsb = mDec[31];
    wrOk = w && !sysRst;
    if (wrOk && a == 2'd0) mDec = d;
    else if (t) mDec = mDec - 32'd1;
    if (wrOk && a == 2'd1) mTbl = d;
    else if (wrOk && a == 2'd2) mTbu = d;
    else if (t) {mTbu, mTbl} = {mTbu, mTbl} + 64'd1;
    expIrq = !sysRst && mDec[31] && !oldMsb;
    @(posedge clk); #1;
    check({31'd0, decIrq}, {31'd0, expIrq}, req, "decIrq");
    tick = 1'b0; regWe = 1'b0;
  endtask

  // driver: queue an expected read for the monitor
  task automatic expectRead(input logic [1:0] a, input string req);
    rdItem_t it;
    @(negedge clk);
    tick = 1'b0; regWe = 1'b0; regAddr = a;
    it.addr = a; it.exp = modelRead(a); it.req = req;
    rdQ.push_back(it);
  endtask

  task automatic readAll(input string req);
    expectRead(2'd0, req);
    expectRead(2'd1, req);
    expectRead(2'd2, req);
  endtask

  // monitor: pops expected reads and compares
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rdQ.size() > 0) begin
        rdItem_t it;
        it = rdQ.pop_front();
        check(regRdata, it.exp, it.req, $sformatf("read addr %0d", it.addr));
      end
    end
  end

  task automatic porPulse();
    @(negedge clk);
    porRst_n = 1'b0;
    mDec = '0; mTbl = '0; mTbu = '0;
    #1;
    check({31'd0, decIrq}, 32'd0, "R1", "decIrq in reset");
    @(negedge clk); @(negedge clk);
    porRst_n = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    porPulse();
    readAll("R1");
    step(0, 0, 2'd0, 0, "R1");

    // R5 load and R2 countdown
    step(0, 1, 2'd0, 32'd5, "R5");
    expectRead(2'd0, "R5");
    for (int i = 0; i < 3; i++) step(1, 0, 2'd0, 0, "R2");
    expectRead(2'd0, "R2");
    step(0, 0, 2'd0, 0, "R2");
    expectRead(2'd0, "R2");

    // R3 time base carry
    step(0, 1, 2'd1, 32'hFFFF_FFFF, "R5");
    step(0, 1, 2'd2, 32'd1, "R5");
    step(1, 0, 2'd0, 0, "R3");
    readAll("R3");
    for (int i = 0; i < 4; i++) step(1, 0, 2'd0, 0, "R3");
    readAll("R3");

    // R4 unmapped address
    expectRead(2'd3, "R4");
    step(0, 1, 2'd3, 32'hDEAD_BEEF, "R4");
    readAll("R4");
    expectRead(2'd3, "R4");

    // R7 crossing by counting
    step(0, 1, 2'd0, 32'd1, "R5");
    step(1, 0, 2'd0, 0, "R7");
    step(1, 0, 2'd0, 0, "R7");
    step(0, 0, 2'd0, 0, "R7");
    expectRead(2'd0, "R7");
    step(1, 0, 2'd0, 0, "R7");

    // R8 crossings by writes
    step(0, 1, 2'd0, 32'h0000_0010, "R8");
    step(0, 1, 2'd0, 32'h8000_0000, "R8");
    step(0, 1, 2'd0, 32'h9000_0000, "R8");
    step(0, 1, 2'd0, 32'h0000_0000, "R8");
    step(0, 0, 2'd0, 0, "R8");

    // R6 write vs tick
    step(1, 1, 2'd0, 32'h0000_0100, "R6");
    expectRead(2'd0, "R6");
    step(1, 1, 2'd1, 32'hFFFF_FFFF, "R6");
    readAll("R6");
    step(1, 1, 2'd2, 32'h0000_0042, "R6");
    readAll("R6");

    // R9 system reset
    step(0, 1, 2'd0, 32'd1, "R9");
    @(negedge clk); sysRst = 1'b1;
    readAll("R9");
    step(1, 0, 2'd0, 0, "R9");
    step(1, 0, 2'd0, 0, "R9");
    step(0, 1, 2'd0, 32'h1234_5678, "R9");
    step(0, 1, 2'd1, 32'h1234_5678, "R9");
    readAll("R9");
    step(1, 0, 2'd0, 0, "R9");
    @(negedge clk); sysRst = 1'b0;
    step(0, 0, 2'd0, 0, "R9");
    step(1, 0, 2'd0, 0, "R9");
    readAll("R9");

    // R1 power-on reset mid-run
    step(0, 1, 2'd2, 32'h5555_AAAA, "R1");
    porPulse();
    readAll("R1");
    step(1, 0, 2'd0, 0, "R7");
    readAll("R3");

    repeat (3) @(negedge clk);
    finish();
  end

endmodule